// File: doc/BRIEF.md
# Two-Bit Handshake Serial Link

This block carries fixed-length frames of bits from a sender to a receiver. The only path between them is one shared 2-bit register, and both ends take turns writing it. The sender accepts a frame through a valid/ready pair. It then places one symbol at a time into the register: a ready marker, a 0-bit code or a 1-bit code. The receiver watches the register. It answers every non-acknowledge value by writing the acknowledge code, and it shifts each data bit it sees into a frame. When it sees the ready marker again after at least one bit, it presents the assembled frame for one cycle.

Because data and handshake share the same two bits, every symbol is a round trip. The sender writes, the receiver answers, and only then may the sender write again. The register value is brought out so that the link traffic can be observed. A stall input holds the receiver back, which models a busy consumer. If the receiver stays silent too long, the sender gives up: it flags an error, leaves the ready marker in the register and returns to idle.

Top module: `hs2_link`

## Requirements
- R1: After reset the channel reads 00, `tx_ready_o` is 1, and `rx_valid_o` and `tx_err_o` are 0.
- R2: Channel codes are: 00 for sender ready or end of frame, 01 for receiver acknowledge, 10 for data bit 0 and 11 for data bit 1. A frame produces the change sequence 00, 01, then a data code followed by 01 for each bit, then 00, followed by the receiver's 01.
- R3: Frame bits go out most significant bit first (bit FRAME_W-1 first). The frame on `rx_data_o` equals the frame accepted on `tx_data_i`.
- R4: Once a data code is on the channel, it changes only to 01. The one exception is a change to 00 in the same cycle that `tx_err_o` is raised.
- R5: Only the receiver writes 01. The channel never changes to 01 in the cycle after a cycle in which `rx_hold_i` was high.
- R6: `rx_valid_o` is a one-cycle pulse. It is raised only in the cycle after the channel read 00 while at least one data bit had been collected.
- R7: `tx_ready_o` is 1 only while the sender is idle. It drops in the cycle after a frame is accepted.
- R8: If no acknowledge arrives within TIMEOUT cycles of the sender entering its wait, `tx_err_o` pulses. This happens TIMEOUT+1 cycles after the accepting edge. In that cycle the channel reads 00 and `tx_ready_o` is 1.
- R9: While `rx_hold_i` is high the receiver writes nothing. Stalls shorter than TIMEOUT only delay frames and do not corrupt them.
- R10: A frame abandoned before any bit was collected produces no `rx_valid_o`. The link then carries the next frame intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | FRAME_W | Frame to send, MSB first |
| tx_valid_i | input | 1 | Frame offered |
| tx_ready_o | output | 1 | Sender idle, frame accepted when valid |
| rx_hold_i | input | 1 | Stall receiver (no acknowledges) |
| rx_data_o | output | FRAME_W | Last assembled frame |
| rx_valid_o | output | 1 | One-cycle frame-complete pulse |
| tx_err_o | output | 1 | One-cycle acknowledge-timeout pulse |
| chan_o | output | 2 | Shared register value |

## Verification
The hardest situation to reach is the sender timing out while the receiver is stalled. That path needs a stall that outlasts the whole timeout window, placed exactly where no bit has yet been collected. The bench holds the receiver stalled from an idle link onward and then offers a frame. It measures the cycle of the error pulse, keeps the stall on to show that the channel stays at 00, and then releases the stall to show that no false frame appears and the next frame arrives intact. Random frames run under random short stalls, and these also land on the end-of-frame marker.

// File: rtl/hs2_pkg.sv
package hs2_pkg;
  typedef enum logic [1:0] {
    CODE_READY = 2'b00,
    CODE_ACK   = 2'b01,
    CODE_D0    = 2'b10,
    CODE_D1    = 2'b11
  } code_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_WAIT
  } tx_state_e;
endpackage

// File: rtl/hs2_chan.sv
module hs2_chan
  import hs2_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_we_i,
  input  logic [1:0]  tx_code_i,
  input  logic        rx_we_i,
  output logic [1:0]  chan_o
);
  // sender write wins a same-cycle collision; receiver retries next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chan_o <= CODE_READY;
    else if (tx_we_i) chan_o <= tx_code_i;
    else if (rx_we_i) chan_o <= CODE_ACK;
  end
endmodule

// File: rtl/hs2_tx.sv
module hs2_tx
  import hs2_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int TIMEOUT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [1:0]         chan_i,
  output logic               we_o,
  output logic [1:0]         code_o,
  output logic               err_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [TO_W-1:0]    tmr_q;
  logic               acked, expire;

  assign acked   = (chan_i == CODE_ACK);
  assign expire  = (state_q == TX_WAIT) && !acked && (tmr_q == TO_LAST);
  assign ready_o = (state_q == TX_IDLE);

  always_comb begin
    we_o   = 1'b0;
    code_o = CODE_READY;
    unique case (state_q)
      TX_START: we_o = 1'b1;
      TX_WAIT: begin
        if (acked) begin
          we_o   = 1'b1;
          code_o = (left_q == '0) ? CODE_READY : {1'b1, sh_q[FRAME_W-1]};
        end else if (expire) begin
          we_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      tmr_q   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= expire;
      unique case (state_q)
        TX_IDLE: if (valid_i) begin
          sh_q    <= data_i;
          left_q  <= CNT_W'(FRAME_W);
          state_q <= TX_START;
        end
        TX_START: begin
          tmr_q   <= '0;
          state_q <= TX_WAIT;
        end
        TX_WAIT: begin
          if (acked) begin
            tmr_q <= '0;
            if (left_q == '0) state_q <= TX_IDLE;
            else begin
              sh_q   <= sh_q << 1;
              left_q <= left_q - 1'b1;
            end
          end else if (expire) begin
            state_q <= TX_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs2_rx.sv
module hs2_rx
  import hs2_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic [1:0]         chan_i,
  output logic               we_o,
  output logic [FRAME_W-1:0] data_o,
  output logic               valid_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  // answer every non-acknowledge value unless stalled
  assign we_o = !hold_i && (chan_i != CODE_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (we_o) begin
        if (chan_i[1]) begin
          sh_q <= (sh_q << 1) | FRAME_W'(chan_i[0]);
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
          if (cnt_q != '0) begin
            data_o  <= sh_q;
            valid_o <= 1'b1;
          end
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/hs2_link.sv
module hs2_link
  import hs2_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int TIMEOUT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic               rx_hold_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               tx_err_o,
  output logic [1:0]         chan_o
);
  logic       tx_we, rx_we;
  logic [1:0] tx_code;

  hs2_tx #(.FRAME_W(FRAME_W), .TIMEOUT(TIMEOUT)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .chan_i  (chan_o),
    .we_o    (tx_we),
    .code_o  (tx_code),
    .err_o   (tx_err_o)
  );

  hs2_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (rx_hold_i),
    .chan_i  (chan_o),
    .we_o    (rx_we),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );

  hs2_chan u_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_we_i   (tx_we),
    .tx_code_i (tx_code),
    .rx_we_i   (rx_we),
    .chan_o    (chan_o)
  );
endmodule

// File: rtl/hs2_link_chk.sv
module hs2_link_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_ready_o,
  input logic       rx_hold_i,
  input logic       rx_valid_o,
  input logic       tx_err_o,
  input logic [1:0] chan_o
);
  a_r4_hold_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chan_o[1]) && (chan_o != $past(chan_o))) |->
      ((chan_o == 2'b01) || (chan_o == 2'b00 && tx_err_o)));

  a_r5_ack_only_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chan_o == 2'b01) && ($past(chan_o) != 2'b01)) |-> !$past(rx_hold_i));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_after_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(chan_o) == 2'b00));

  a_r8_timeout_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> ((chan_o == 2'b00) && tx_ready_o));
endmodule

bind hs2_link hs2_link_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_ready_o (tx_ready_o),
  .rx_hold_i  (rx_hold_i),
  .rx_valid_o (rx_valid_o),
  .tx_err_o   (tx_err_o),
  .chan_o     (chan_o)
);

// File: tb/hs2_link_tb_top.sv
module hs2_link_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W  = 8;
  localparam int TO = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic         hold_dir = 1'b0, hold_rnd = 1'b0;
  logic [W-1:0] rx_data;
  logic         rx_valid, tx_err;
  logic [1:0]   chan;

  int errs = 0, checks = 0, cyc = 0, burst = 0;
  bit stall_en = 1'b0, log_en = 1'b0;
  logic [1:0] prev_chan = 2'b00;
  logic [1:0] log_q[$];

  always #2 clk = ~clk;

  hs2_link #(.FRAME_W(W), .TIMEOUT(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_hold_i(hold_dir | hold_rnd), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .tx_err_o(tx_err), .chan_o(chan));

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      finish_run();
    end
  end

  // short random receiver stalls, always separated by a free cycle
  always @(negedge clk) begin
    if (burst != 0) begin hold_rnd = 1'b1; burst--; end
    else begin
      hold_rnd = 1'b0;
      if (stall_en && ($urandom % 8 == 0)) burst = 1 + ($urandom % 5);
    end
  end

  always @(negedge clk) begin
    if (log_en && chan != prev_chan) log_q.push_back(chan);
    prev_chan = chan;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output bit got, input int max);
    got = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1'b1; return; end
    end
  endtask

  task automatic xfer(input logic [W-1:0] d, input string req);
    bit got;
    send(d);
    wait_rx(got, 2000);
    chk(got, req, {31'd0, got}, 32'd1);
    if (got) chk(rx_data == d, req, 32'(rx_data), 32'(d));
  endtask

  function automatic logic [1:0] exp_code(input logic [W-1:0] d, input int k);
    // k: index into change log of one frame
    if (k == 0) return 2'b00;
    if (k == 1) return 2'b01;
    if (k < 2 + 2 * W) return (k % 2 == 0) ? {1'b1, d[W - 1 - (k - 2) / 2]} : 2'b01;
    if (k == 2 + 2 * W) return 2'b00;
    return 2'b01;
  endfunction

  initial begin
    bit got;
    int n;
    logic [W-1:0] d;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(chan == 2'b00, "R1 chan", 32'(chan), 32'h0);
    chk(tx_ready == 1'b1, "R1 tx_ready", 32'(tx_ready), 32'h1);
    chk(!rx_valid && !tx_err, "R1 flags", {30'd0, rx_valid, tx_err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(chan == 2'b01, "R2 idle ack", 32'(chan), 32'h1);

    // R2/R3: exact channel sequence, MSB first
    d = 8'b1010_0110;
    log_q.delete();
    log_en = 1'b1;
    xfer(d, "R3 directed frame");
    repeat (3) @(negedge clk);
    log_en = 1'b0;
    chk(log_q.size() == 4 + 2 * W, "R2 change count", 32'(log_q.size()), 32'(4 + 2 * W));
    for (int k = 0; k < log_q.size() && k < 4 + 2 * W; k++)
      chk(log_q[k] == exp_code(d, k), "R2 sequence", 32'(log_q[k]), 32'(exp_code(d, k)));

    // R7: ready drops in cycle after accept
    send(8'h3c);
    chk(tx_ready == 1'b0, "R7 busy", 32'(tx_ready), 32'h0);
    wait_rx(got, 2000);
    chk(got && rx_data == 8'h3c, "R7 frame", 32'(rx_data), 32'h3c);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R7 idle again", 32'(tx_ready), 32'h1);

    // R3 corners
    xfer('0, "R3 all zeros");
    xfer('1, "R3 all ones");

    // R8/R9/R10: stall outlasting timeout
    hold_dir = 1'b1;
    send(8'h96);
    n = 0;
    for (int i = 0; i < 4 * TO; i++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (tx_err) break;
    end
    chk(n == TO + 1, "R8 timeout cycle", 32'(n), 32'(TO + 1));
    chk(chan == 2'b00 && tx_ready, "R8 idle after timeout", {29'd0, tx_ready, chan}, 32'h4);
    repeat (10) @(negedge clk);
    chk(chan == 2'b00, "R9 no ack while held", 32'(chan), 32'h0);
    hold_dir = 1'b0;
    wait_rx(got, 20);
    chk(!got, "R10 no false frame", {31'd0, got}, 32'h0);
    chk(chan == 2'b01, "R10 link re-acked", 32'(chan), 32'h1);
    xfer(8'h5a, "R10 next frame intact");

    // R9: random frames under short stalls
    stall_en = 1'b1;
    for (int f = 0; f < 60; f++) xfer(W'($urandom), "R9 random frame");
    stall_en = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule